// File: doc/BRIEF.md
# Up/Down Counter Field with Thresholds and Saturation

This block is a hardware-updated counter field of the kind found in status and statistics registers. Two single-cycle strobes move the count: one steps it up and one steps it down. A small write port lets the surrounding register logic clear the count or load a value into it. Decoding the register bus is left to the logic around the block.

The count is compared against two build-time limits. The upper flag is high while the count is at or above its limit, and the lower flag is high while the count is at or below its limit. A build-time mode selects the behaviour at the ends of the range. In wrapping mode the count rolls over and a one-cycle event marks each rollover. In saturating mode the count stops at the end of the range, and a flag stays high for as long as the count sits at that end.

Top module: `updown_cnt_field`

## Requirements
- R1: After reset the count is 0, both wrap events are low, the lower-limit flag reflects a count of 0, and in saturating mode the bottom-saturation flag is high.
- R2: With no clear or load, an up strobe alone raises the count by one at the next clock edge, and a down strobe alone lowers it by one. This holds wherever the count is not at the end of the range in that direction.
- R3: When both strobes are high in the same cycle, the count does not change and neither wrap event fires, even at 0 or at the maximum.
- R4: A clear takes priority over load and both strobes: the count is 0 after the next edge, and no event fires in the clear cycle.
- R5: A load without clear puts the load value into the count at the next edge. Any strobes in that cycle are ignored and fire no event.
- R6: `upper_hit_o` is high exactly when the count is greater than or equal to `UP_LIMIT`.
- R7: `lower_hit_o` is high exactly when the count is less than or equal to `DOWN_LIMIT`.
- R8: In wrapping mode, an up strobe alone at the maximum count (all ones) moves the count to 0. `wrap_up_o` is high during the cycle that strobe is presented, and only then.
- R9: In wrapping mode, a down strobe alone at a count of 0 moves the count to the maximum. `wrap_down_o` is high during the cycle that strobe is presented, and only then.
- R10: In saturating mode, further up strobes at the maximum and further down strobes at 0 leave the count unchanged, and the wrap events never fire.
- R11: In saturating mode, `top_sat_o` is high exactly while the count equals the maximum and `bottom_sat_o` is high exactly while it equals 0. In wrapping mode both flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the count (highest priority) |
| load_i | input | 1 | Load `load_val_i` into the count |
| load_val_i | input | WIDTH | Value used by a load |
| up_i | input | 1 | Step-up strobe |
| down_i | input | 1 | Step-down strobe |
| count_o | output | WIDTH | Current count |
| upper_hit_o | output | 1 | Count is at or above `UP_LIMIT` |
| lower_hit_o | output | 1 | Count is at or below `DOWN_LIMIT` |
| wrap_up_o | output | 1 | Rollover from the maximum to 0 in this cycle |
| wrap_down_o | output | 1 | Rollover from 0 to the maximum in this cycle |
| top_sat_o | output | 1 | Saturating mode, count held at the maximum |
| bottom_sat_o | output | 1 | Saturating mode, count held at 0 |

## Verification
Every cycle, the bound checker confirms the following. Each single-direction step moves the count by exactly one. Opposing strobes and saturated strobes hold the count, clear beats load, and a load lands its value. Each wrap event is followed by the matching rollover value, and the saturation flags are never both high and persist while the count is held. The bench scenarios are what show the exact values at the thresholds, the reset state and the flags in each mode. Only the bench places the two modes side by side under identical strobes, which shows that one rolls over and the other stops.

// File: rtl/cnt_field_pkg.sv
package cnt_field_pkg;

    typedef enum logic {
        MODE_WRAP = 1'b0,
        MODE_SAT  = 1'b1
    } cnt_mode_e;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_UP    = 3'd3,
        OP_DOWN  = 3'd4
    } cnt_op_e;

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_field_pkg::*;
(
    input  logic    clear_i,
    input  logic    load_i,
    input  logic    up_i,
    input  logic    down_i,
    output cnt_op_e op_o
);

    // Priority: clear, then load, then a single strobe; opposing strobes cancel.
    always_comb begin
        if (clear_i) begin
            op_o = OP_CLEAR;
        end else if (load_i) begin
            op_o = OP_LOAD;
        end else if (up_i && !down_i) begin
            op_o = OP_UP;
        end else if (down_i && !up_i) begin
            op_o = OP_DOWN;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/cnt_step.sv
module cnt_step
    import cnt_field_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter cnt_mode_e   MODE  = MODE_WRAP
) (
    input  logic [WIDTH-1:0] count_i,
    input  cnt_op_e          op_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] next_o,
    output logic             wrap_up_o,
    output logic             wrap_down_o
);

    localparam logic [WIDTH-1:0] MAX_VAL = '1;
    localparam logic [WIDTH-1:0] MIN_VAL = '0;
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

    logic at_max;
    logic at_min;
    logic [WIDTH-1:0] plus_one;
    logic [WIDTH-1:0] minus_one;

    assign at_max    = (count_i == MAX_VAL);
    assign at_min    = (count_i == MIN_VAL);
    assign plus_one  = count_i + ONE;
    assign minus_one = count_i - ONE;

    generate
        if (MODE == MODE_SAT) begin : g_sat
            always_comb begin
                wrap_up_o   = 1'b0;
                wrap_down_o = 1'b0;
                unique case (op_i)
                    OP_CLEAR: next_o = MIN_VAL;
                    OP_LOAD:  next_o = load_val_i;
                    OP_UP:    next_o = at_max ? MAX_VAL : plus_one;
                    OP_DOWN:  next_o = at_min ? MIN_VAL : minus_one;
                    default:  next_o = count_i;
                endcase
            end
        end else begin : g_wrap
            always_comb begin
                wrap_up_o   = (op_i == OP_UP) && at_max;
                wrap_down_o = (op_i == OP_DOWN) && at_min;
                unique case (op_i)
                    OP_CLEAR: next_o = MIN_VAL;
                    OP_LOAD:  next_o = load_val_i;
                    OP_UP:    next_o = plus_one;
                    OP_DOWN:  next_o = minus_one;
                    default:  next_o = count_i;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/cnt_flags.sv
module cnt_flags
    import cnt_field_pkg::*;
#(
    parameter int unsigned WIDTH      = 4,
    parameter int unsigned UP_LIMIT   = 6,
    parameter int unsigned DOWN_LIMIT = 7,
    parameter cnt_mode_e   MODE       = MODE_WRAP
) (
    input  logic [WIDTH-1:0] count_i,
    output logic             upper_hit_o,
    output logic             lower_hit_o,
    output logic             top_sat_o,
    output logic             bottom_sat_o
);

    localparam logic [WIDTH-1:0] MAX_VAL = '1;
    localparam logic [WIDTH-1:0] MIN_VAL = '0;

    logic [31:0] count_ext;

    assign count_ext   = 32'(count_i);
    assign upper_hit_o = (count_ext >= 32'(UP_LIMIT));
    assign lower_hit_o = (count_ext <= 32'(DOWN_LIMIT));

    generate
        if (MODE == MODE_SAT) begin : g_sat_flags
            assign top_sat_o    = (count_i == MAX_VAL);
            assign bottom_sat_o = (count_i == MIN_VAL);
        end else begin : g_no_sat_flags
            assign top_sat_o    = 1'b0;
            assign bottom_sat_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/updown_cnt_field.sv
module updown_cnt_field
    import cnt_field_pkg::*;
#(
    parameter int unsigned WIDTH      = 4,
    parameter int unsigned UP_LIMIT   = 6,
    parameter int unsigned DOWN_LIMIT = 7,
    parameter cnt_mode_e   MODE       = MODE_WRAP
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             up_i,
    input  logic             down_i,
    output logic [WIDTH-1:0] count_o,
    output logic             upper_hit_o,
    output logic             lower_hit_o,
    output logic             wrap_up_o,
    output logic             wrap_down_o,
    output logic             top_sat_o,
    output logic             bottom_sat_o
);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } cnt_state_t;

    cnt_state_t       state_d;
    cnt_state_t       state_q;
    cnt_op_e          op;
    logic [WIDTH-1:0] step_next;

    cnt_op_decode u_decode (
        .clear_i (clear_i),
        .load_i  (load_i),
        .up_i    (up_i),
        .down_i  (down_i),
        .op_o    (op)
    );

    cnt_step #(
        .WIDTH (WIDTH),
        .MODE  (MODE)
    ) u_step (
        .count_i     (state_q.count),
        .op_i        (op),
        .load_val_i  (load_val_i),
        .next_o      (step_next),
        .wrap_up_o   (wrap_up_o),
        .wrap_down_o (wrap_down_o)
    );

    cnt_flags #(
        .WIDTH      (WIDTH),
        .UP_LIMIT   (UP_LIMIT),
        .DOWN_LIMIT (DOWN_LIMIT),
        .MODE       (MODE)
    ) u_flags (
        .count_i      (state_q.count),
        .upper_hit_o  (upper_hit_o),
        .lower_hit_o  (lower_hit_o),
        .top_sat_o    (top_sat_o),
        .bottom_sat_o (bottom_sat_o)
    );

    always_comb begin
        state_d       = state_q;
        state_d.count = step_next;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.count;

endmodule

// File: rtl/updown_cnt_field_chk.sv
module updown_cnt_field_chk
    import cnt_field_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter cnt_mode_e   MODE  = MODE_WRAP
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clear_i,
    input logic             load_i,
    input logic [WIDTH-1:0] load_val_i,
    input logic             up_i,
    input logic             down_i,
    input logic [WIDTH-1:0] count_o,
    input logic             wrap_up_o,
    input logic             wrap_down_o,
    input logic             top_sat_o,
    input logic             bottom_sat_o
);

    localparam logic [WIDTH-1:0] MAX_VAL = '1;
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
    localparam bit               IS_SAT  = (MODE == MODE_SAT);

    logic quiet;
    assign quiet = !clear_i && !load_i;

    a_r2_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet && up_i && !down_i && count_o != MAX_VAL)
        |=> count_o == $past(count_o) + ONE);

    a_r2_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet && down_i && !up_i && count_o != '0)
        |=> count_o == $past(count_o) - ONE);

    a_r3_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet && up_i && down_i) |=> $stable(count_o));

    a_r3_no_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (up_i && down_i) |-> (!wrap_up_o && !wrap_down_o));

    a_r4_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> count_o == '0);

    a_r5_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !clear_i) |=> count_o == $past(load_val_i));

    a_r8_wrap_up_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_up_o |=> count_o == '0);

    a_r9_wrap_down_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_down_o |=> count_o == MAX_VAL);

    a_r10_sat_hold_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (IS_SAT && quiet && up_i && !down_i && count_o == MAX_VAL)
        |=> count_o == MAX_VAL);

    a_r10_sat_no_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (IS_SAT && (up_i || down_i)) |-> (!wrap_up_o && !wrap_down_o));

    a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({top_sat_o, bottom_sat_o}));

    a_r11_top_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (top_sat_o && quiet && !down_i) |=> top_sat_o);

endmodule

bind updown_cnt_field updown_cnt_field_chk #(
    .WIDTH (WIDTH),
    .MODE  (MODE)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .load_i       (load_i),
    .load_val_i   (load_val_i),
    .up_i         (up_i),
    .down_i       (down_i),
    .count_o      (count_o),
    .wrap_up_o    (wrap_up_o),
    .wrap_down_o  (wrap_down_o),
    .top_sat_o    (top_sat_o),
    .bottom_sat_o (bottom_sat_o)
);

// File: tb/updown_cnt_field_bench.sv
module updown_cnt_field_bench;
    import cnt_field_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int UP_LIM     = 6;
    localparam int DN_LIM     = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         ld = 1'b0;
    logic [W-1:0] ld_val = '0;
    logic         up = 1'b0;
    logic         dn = 1'b0;

    logic [W-1:0] w_cnt, s_cnt;
    logic w_uh, w_lh, w_ovf, w_unf, w_ts, w_bs;
    logic s_uh, s_lh, s_ovf, s_unf, s_ts, s_bs;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updown_cnt_field #(.WIDTH(W), .UP_LIMIT(UP_LIM), .DOWN_LIMIT(DN_LIM), .MODE(MODE_WRAP))
    u_updown_cnt_field (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .load_i(ld), .load_val_i(ld_val),
        .up_i(up), .down_i(dn), .count_o(w_cnt), .upper_hit_o(w_uh), .lower_hit_o(w_lh),
        .wrap_up_o(w_ovf), .wrap_down_o(w_unf), .top_sat_o(w_ts), .bottom_sat_o(w_bs)
    );

    updown_cnt_field #(.WIDTH(W), .UP_LIMIT(UP_LIM), .DOWN_LIMIT(DN_LIM), .MODE(MODE_SAT))
    u_updown_cnt_field_sat (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .load_i(ld), .load_val_i(ld_val),
        .up_i(up), .down_i(dn), .count_o(s_cnt), .upper_hit_o(s_uh), .lower_hit_o(s_lh),
        .wrap_up_o(s_ovf), .wrap_down_o(s_unf), .top_sat_o(s_ts), .bottom_sat_o(s_bs)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Inputs change 1 time unit after a rising edge; outputs are read after that.
    task automatic drive(input logic c, input logic l, input int v, input logic u, input logic d);
        clr = c; ld = l; ld_val = W'(v); up = u; dn = d;
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic go_to(input int v);
        drive(0, 1, v, 0, 0);
        step();
        drive(0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        check("R1 wrap count", int'(w_cnt), 0);
        check("R1 sat count", int'(s_cnt), 0);
        check("R1 wrap events", int'({w_ovf, w_unf}), 0);
        check("R1 lower flag", int'(w_lh), 1);
        check("R1 R11 sat bottom flag", int'(s_bs), 1);
        check("R11 wrap sat flags low", int'({w_ts, w_bs}), 0);
    endtask

    task automatic t_count_up();
        drive(1, 0, 0, 0, 0);
        step();
        drive(0, 0, 0, 1, 0);
        for (int i = 1; i <= 9; i++) begin
            step();
            check("R2 up wrap", int'(w_cnt), i);
            check("R2 up sat", int'(s_cnt), i);
            check("R6 upper flag", int'(w_uh), (i >= UP_LIM) ? 1 : 0);
            check("R7 lower flag", int'(w_lh), (i <= DN_LIM) ? 1 : 0);
        end
        drive(0, 0, 0, 0, 1);
        for (int i = 8; i >= 5; i--) begin
            step();
            check("R2 down wrap", int'(w_cnt), i);
            check("R7 lower flag down", int'(s_lh), (i <= DN_LIM) ? 1 : 0);
        end
        drive(0, 0, 0, 0, 0);
    endtask

    task automatic t_both();
        go_to(10);
        drive(0, 0, 0, 1, 1);
        step();
        check("R3 both hold", int'(w_cnt), 10);
        go_to(15);
        drive(0, 0, 0, 1, 1);
        check("R3 no wrap at max", int'(w_ovf), 0);
        step();
        check("R3 hold at max", int'(w_cnt), 15);
        go_to(0);
        drive(0, 0, 0, 1, 1);
        check("R3 no wrap at zero", int'(w_unf), 0);
        step();
        check("R3 hold at zero", int'(w_cnt), 0);
        drive(0, 0, 0, 0, 0);
    endtask

    task automatic t_load_clear();
        go_to(3);
        drive(0, 1, 9, 1, 0);
        step();
        check("R5 load beats strobe", int'(w_cnt), 9);
        go_to(15);
        drive(0, 1, 2, 1, 0);
        check("R5 no event on load", int'(w_ovf), 0);
        step();
        check("R5 load value", int'(s_cnt), 2);
        drive(1, 1, 12, 1, 0);
        step();
        check("R4 clear wins wrap", int'(w_cnt), 0);
        check("R4 clear wins sat", int'(s_cnt), 0);
        go_to(15);
        drive(1, 0, 0, 1, 0);
        check("R4 no event on clear", int'(w_ovf), 0);
        step();
        check("R4 cleared at max", int'(w_cnt), 0);
        drive(0, 0, 0, 0, 0);
    endtask

    task automatic t_top_end();
        go_to(14);
        drive(0, 0, 0, 1, 0);
        check("R8 no wrap below max", int'(w_ovf), 0);
        step();
        check("R8 reach max", int'(w_cnt), 15);
        check("R8 wrap event", int'(w_ovf), 1);
        check("R10 sat no event", int'(s_ovf), 0);
        check("R11 top flag sat", int'(s_ts), 1);
        check("R11 top flag wrap low", int'(w_ts), 0);
        step();
        check("R8 rolled to zero", int'(w_cnt), 0);
        check("R8 event one cycle", int'(w_ovf), 0);
        check("R10 sat holds max", int'(s_cnt), 15);
        check("R11 top flag stays", int'(s_ts), 1);
        step();
        check("R10 sat still max", int'(s_cnt), 15);
        drive(0, 0, 0, 0, 1);
        step();
        check("R11 top flag drops", int'(s_ts), 0);
        drive(0, 0, 0, 0, 0);
    endtask

    task automatic t_bottom_end();
        drive(1, 0, 0, 0, 0);
        step();
        drive(0, 0, 0, 0, 1);
        check("R9 wrap down event", int'(w_unf), 1);
        check("R10 sat no down event", int'(s_unf), 0);
        step();
        check("R9 rolled to max", int'(w_cnt), 15);
        check("R9 event one cycle", int'(w_unf), 0);
        check("R10 sat holds zero", int'(s_cnt), 0);
        check("R11 bottom flag stays", int'(s_bs), 1);
        check("R7 lower flag at max", int'(w_lh), 0);
        check("R6 upper flag at max", int'(w_uh), 1);
        drive(0, 0, 0, 1, 0);
        step();
        check("R11 bottom flag drops", int'(s_bs), 0);
        drive(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        t_reset();
        t_count_up();
        t_both();
        t_load_clear();
        t_top_end();
        t_bottom_end();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule